// File: doc/BRIEF.md
# Boot-Sector Write Lock Unit

This block keeps one lock flag for each of the eleven erase sectors of a 512 KB byte-addressed flash array. The sectors are not all the same size. There is a 16 KB boot sector, two 8 KB parameter sectors, a 32 KB sector and seven 64 KB sectors. A build parameter places the small sectors either at the top or at the bottom of the address space. The sector is found from the six upper address bits. The block answers two questions combinationally: may a program or erase proceed at a given address, and is a given sector locked. The second answer comes back as a verify byte.

Locking one sector takes a fixed number of clock cycles. Clearing every lock at once takes a longer fixed number of cycles. A busy flag is high while either operation runs. The clear is accepted only when all eleven sectors are already locked. A level input models the high-voltage override. While it is high, every sector may be written and the stored flags stay unchanged. A reset returns the sequencer to idle and leaves the lock flags as they were.

Top module: `sector_lock_unit`

## Requirements
- R1: With TOP_BOOT=1, sector starts are 00000h, 10000h, 20000h, 30000h, 40000h, 50000h, 60000h (64 KB each), 70000h (32 KB), 78000h and 7A000h (8 KB each) and 7C000h (16 KB, ending at 7FFFFh); every address in a sector maps to that sector.
- R2: With TOP_BOOT=0, sector starts are 00000h (16 KB), 04000h and 06000h (8 KB each), 08000h (32 KB), then 10000h through 70000h in 64 KB steps; every address in a sector maps to that sector.
- R3: vfy_data reads 01h when the sector holding vfy_addr is locked and 00h otherwise; temp_unlock does not change it.
- R4: pe_allow is 0 for any address in a locked sector and 1 for any address in an unlocked sector while temp_unlock is 0.
- R5: While temp_unlock is 1, pe_allow is 1 for every address. Returning it to 0 restores the answer given by the stored flags.
- R6: A lock request taken while idle keeps busy high for exactly PROT_CYC cycles. The sector's flag becomes 1 at the edge that ends busy, and no flag changes while busy is high.
- R7: A clear request taken while idle is accepted only when all eleven flags are 1. Otherwise busy stays 0 and no flag changes.
- R8: An accepted clear keeps busy high for exactly UNPROT_CYC cycles and then sets all eleven flags to 0 together.
- R9: Requests arriving while busy are ignored. A lock request and a clear request in the same idle cycle start the lock only.
- R10: Reset forces busy to 0 and abandons any running operation. It never changes a lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cmd_protect | input | 1 | Request to lock the sector holding cmd_addr |
| cmd_unprot_all | input | 1 | Request to clear every lock flag |
| cmd_addr | input | ADDR_W | Byte address selecting the sector to lock |
| temp_unlock | input | 1 | Override level: while high, all sectors are writable |
| pe_addr | input | ADDR_W | Address of a pending program or erase |
| pe_allow | output | 1 | 1 when the access at pe_addr may proceed |
| vfy_addr | input | ADDR_W | Address whose sector lock is read back |
| vfy_data | output | 8 | 01h if that sector is locked, else 00h |
| busy | output | 1 | A lock or clear operation is running |

## Verification
Two collisions are provoked. In the first, a lock request and a clear request arrive in the same idle cycle while every sector is locked. The bench judges the outcome by busy lasting PROT_CYC cycles rather than UNPROT_CYC, and by every sector still reading 01h afterwards. In the second, a new lock request arrives while a lock is still running. The verify byte of the first sector is sampled in the last busy cycle and must still read 00h, and the second sector must stay unlocked after the operation ends.

// File: rtl/slu_pkg.sv
package slu_pkg;
   localparam int NBLK  = 11;
   localparam int IDX_W = $clog2(NBLK);
   localparam int SEC_W = 6;

   typedef logic [IDX_W-1:0] blk_idx_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SET   = 2'd1,
      SQ_CLEAR = 2'd2
   } seq_e;

   // Select one flag from the lock vector by sector index.
   function automatic logic pick_bit(input logic [NBLK-1:0] v, input blk_idx_t i);
      pick_bit = 1'b0;
      for (int b = 0; b < NBLK; b++) begin
         if (i == blk_idx_t'(b)) pick_bit = v[b];
      end
   endfunction
endpackage

// File: rtl/slu_decode.sv
module slu_decode
   import slu_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter bit TOP_BOOT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output blk_idx_t          idx
);
   localparam int LOW_W = ADDR_W - SEC_W;

   logic [SEC_W-1:0] sec;
   logic [2:0]       big;
   logic [2:0]       sub;
   logic             unused_low;

   assign sec        = addr[ADDR_W-1 -: SEC_W];
   assign big        = sec[5:3];
   assign sub        = sec[2:0];
   assign unused_low = ^addr[LOW_W-1:0];

   generate
      if (TOP_BOOT) begin : g_top
         // Small sectors fill the last 64 KB slot.
         always_comb begin
            if (big != 3'd7)       idx = blk_idx_t'(big);
            else if (sub <= 3'd3)  idx = blk_idx_t'(7);
            else if (sub == 3'd4)  idx = blk_idx_t'(8);
            else if (sub == 3'd5)  idx = blk_idx_t'(9);
            else                   idx = blk_idx_t'(10);
         end
      end else begin : g_bottom
         // Small sectors fill the first 64 KB slot.
         always_comb begin
            if (big != 3'd0)       idx = blk_idx_t'(big) + blk_idx_t'(3);
            else if (sub <= 3'd1)  idx = blk_idx_t'(0);
            else if (sub == 3'd2)  idx = blk_idx_t'(1);
            else if (sub == 3'd3)  idx = blk_idx_t'(2);
            else                   idx = blk_idx_t'(3);
         end
      end
   endgenerate
endmodule

// File: rtl/slu_timer.sv
module slu_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign done = run_q & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= len - CNT_W'(1);
      end else if (done) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/slu_lockbank.sv
module slu_lockbank
   import slu_pkg::*;
(
   input  logic            clk,
   input  logic            set_en,
   input  blk_idx_t        set_idx,
   input  logic            clr_all,
   output logic [NBLK-1:0] bits,
   output logic            all_set
);
   // No reset: the flags are retained across sequencer resets.
   generate
      for (genvar b = 0; b < NBLK; b++) begin : g_bit
         logic flag_q;
         always_ff @(posedge clk) begin
            if (clr_all)                                 flag_q <= 1'b0;
            else if (set_en && set_idx == blk_idx_t'(b)) flag_q <= 1'b1;
         end
         assign bits[b] = flag_q;
      end
   endgenerate

   assign all_set = &bits;
endmodule

// File: rtl/sector_lock_unit.sv
module sector_lock_unit
   import slu_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter bit TOP_BOOT   = 1'b1,
   parameter int PROT_CYC   = 12500,
   parameter int UNPROT_CYC = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_protect,
   input  logic              cmd_unprot_all,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              temp_unlock,
   input  logic [ADDR_W-1:0] pe_addr,
   output logic              pe_allow,
   input  logic [ADDR_W-1:0] vfy_addr,
   output logic [7:0]        vfy_data,
   output logic              busy
);
   localparam int LONGEST = (PROT_CYC > UNPROT_CYC) ? PROT_CYC : UNPROT_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int NPORT   = 3;   // 0: command, 1: program/erase query, 2: verify

   generate
      if (ADDR_W != 19) begin : g_bad_aw
         $error("sector_lock_unit: ADDR_W must be 19");
      end
      if (PROT_CYC < 1) begin : g_bad_pc
         $error("sector_lock_unit: PROT_CYC must be at least 1");
      end
      if (UNPROT_CYC < 1) begin : g_bad_uc
         $error("sector_lock_unit: UNPROT_CYC must be at least 1");
      end
   endgenerate

   logic [NPORT-1:0][ADDR_W-1:0] dec_addr;
   blk_idx_t                     dec_idx [NPORT];

   assign dec_addr[0] = cmd_addr;
   assign dec_addr[1] = pe_addr;
   assign dec_addr[2] = vfy_addr;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_dec
         slu_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dec (
            .addr (dec_addr[p]),
            .idx  (dec_idx[p])
         );
      end
   endgenerate

   seq_e             state_q, state_d;
   blk_idx_t         tgt_q;
   logic             tmr_start, tmr_done;
   logic [CNT_W-1:0] tmr_len;
   logic [NBLK-1:0]  lock_vec;
   logic             all_locked;
   logic             set_en, clr_all;

   always_comb begin
      state_d   = state_q;
      tmr_start = 1'b0;
      tmr_len   = CNT_W'(PROT_CYC);
      set_en    = 1'b0;
      clr_all   = 1'b0;
      case (state_q)
         SQ_IDLE: begin
            if (cmd_protect) begin
               state_d   = SQ_SET;
               tmr_start = 1'b1;
            end else if (cmd_unprot_all && all_locked) begin
               state_d   = SQ_CLEAR;
               tmr_start = 1'b1;
               tmr_len   = CNT_W'(UNPROT_CYC);
            end
         end
         SQ_SET: begin
            if (tmr_done) begin
               set_en  = 1'b1;
               state_d = SQ_IDLE;
            end
         end
         SQ_CLEAR: begin
            if (tmr_done) begin
               clr_all = 1'b1;
               state_d = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         tgt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && cmd_protect) tgt_q <= dec_idx[0];
      end
   end

   slu_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .len   (tmr_len),
      .done  (tmr_done)
   );

   slu_lockbank u_bank (
      .clk     (clk),
      .set_en  (set_en),
      .set_idx (tgt_q),
      .clr_all (clr_all),
      .bits    (lock_vec),
      .all_set (all_locked)
   );

   assign busy     = (state_q != SQ_IDLE);
   assign pe_allow = temp_unlock | ~pick_bit(lock_vec, dec_idx[1]);
   assign vfy_data = {7'b0, pick_bit(lock_vec, dec_idx[2])};
endmodule

// File: rtl/slu_checker.sv
module slu_checker
   import slu_pkg::*;
#(
   parameter int PROT_CYC   = 1,
   parameter int UNPROT_CYC = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            cmd_protect,
   input logic            cmd_unprot_all,
   input logic            temp_unlock,
   input logic            pe_allow,
   input logic [NBLK-1:0] lock_vec
);
   int run_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len_q <= 0;
      else if (busy) run_len_q <= run_len_q + 1;
      else           run_len_q <= 0;
   end

   assert_op_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len_q == PROT_CYC || run_len_q == UNPROT_CYC));

   assert_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(lock_vec));

   assert_single_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_vec & ~$past(lock_vec)) != '0) |->
         ($countones(lock_vec ^ $past(lock_vec)) == 1 && $fell(busy)));

   assert_unlock_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(cmd_unprot_all) && !$past(cmd_protect)) |-> $past(&lock_vec));

   assert_clear_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((~lock_vec & $past(lock_vec)) != '0) |->
         (lock_vec == '0 && $past(lock_vec) == '1 && $fell(busy)));

   assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
      temp_unlock |-> pe_allow);
endmodule

bind sector_lock_unit slu_checker #(.PROT_CYC(PROT_CYC), .UNPROT_CYC(UNPROT_CYC)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy           (busy),
   .cmd_protect    (cmd_protect),
   .cmd_unprot_all (cmd_unprot_all),
   .temp_unlock    (temp_unlock),
   .pe_allow       (pe_allow),
   .lock_vec       (lock_vec)
);

// File: tb/sector_lock_unit_test.sv
module sector_lock_unit_test;
   localparam int PC = 6;
   localparam int UC = 15;
   localparam logic [18:0] BASE_T [11] = '{19'h00000, 19'h10000, 19'h20000, 19'h30000,
      19'h40000, 19'h50000, 19'h60000, 19'h70000, 19'h78000, 19'h7A000, 19'h7C000};
   localparam logic [18:0] BASE_B [11] = '{19'h00000, 19'h04000, 19'h06000, 19'h08000,
      19'h10000, 19'h20000, 19'h30000, 19'h40000, 19'h50000, 19'h60000, 19'h70000};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_protect = 1'b0, cmd_unprot_all = 1'b0, temp_unlock = 1'b0;
   logic [18:0] cmd_addr_t = '0, cmd_addr_b = '0, pe_addr_t = '0, pe_addr_b = '0;
   logic [18:0] vfy_addr_t = '0, vfy_addr_b = '0;
   logic pe_allow_t, pe_allow_b, busy_t, busy_b;
   logic [7:0] vfy_t, vfy_b;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sector_lock_unit #(.TOP_BOOT(1'b1), .PROT_CYC(PC), .UNPROT_CYC(UC)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_protect(cmd_protect), .cmd_unprot_all(cmd_unprot_all),
      .cmd_addr(cmd_addr_t), .temp_unlock(temp_unlock), .pe_addr(pe_addr_t),
      .pe_allow(pe_allow_t), .vfy_addr(vfy_addr_t), .vfy_data(vfy_t), .busy(busy_t));

   sector_lock_unit #(.TOP_BOOT(1'b0), .PROT_CYC(PC), .UNPROT_CYC(UC)) uut_bot (
      .clk(clk), .rst_n(rst_n), .cmd_protect(cmd_protect), .cmd_unprot_all(cmd_unprot_all),
      .cmd_addr(cmd_addr_b), .temp_unlock(temp_unlock), .pe_addr(pe_addr_b),
      .pe_allow(pe_allow_b), .vfy_addr(vfy_addr_b), .vfy_data(vfy_b), .busy(busy_b));

   function automatic logic [18:0] last_of(input bit top, input int i);
      if (i == 10) return 19'h7FFFF;
      return (top ? BASE_T[i+1] : BASE_B[i+1]) - 19'd1;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic look(input logic [18:0] at, input logic [18:0] ab);
      vfy_addr_t = at; vfy_addr_b = ab; pe_addr_t = at; pe_addr_b = ab;
      #1;
   endtask

   task automatic issue(input bit prot, input bit unp, input logic [18:0] at, input logic [18:0] ab);
      @(negedge clk);
      cmd_addr_t = at; cmd_addr_b = ab; cmd_protect = prot; cmd_unprot_all = unp;
      @(negedge clk);
      cmd_protect = 1'b0; cmd_unprot_all = 1'b0;
   endtask

   task automatic count_busy(output int nt, output int nb);
      nt = 0; nb = 0;
      while ((busy_t || busy_b) && (nt + nb) < 2000) begin
         if (busy_t) nt++;
         if (busy_b) nb++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R10 watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int nt, nb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset busy top", busy_t, 0);
      chk("R10 reset busy bottom", busy_b, 0);

      // Bring the flags to a known state: lock all, then clear all.
      for (int i = 0; i < 11; i++) begin
         issue(1, 0, BASE_T[i], BASE_B[i]);
         count_busy(nt, nb);
      end
      issue(0, 1, 19'h0, 19'h0);
      count_busy(nt, nb);
      chk("R8 clear busy length top", nt, UC);
      chk("R8 clear busy length bottom", nb, UC);
      for (int i = 0; i < 11; i++) begin
         look(BASE_T[i], BASE_B[i]);
         chk("R8 cleared top", vfy_t, 8'h00);
         chk("R8 cleared bottom", vfy_b, 8'h00);
         chk("R4 unlocked allowed top", pe_allow_t, 1);
      end

      // Lock one sector, an in-flight request arrives and must be ignored.
      issue(1, 0, BASE_T[2], BASE_B[2]);
      nt = 0;
      while (busy_t && nt < 1000) begin
         nt++;
         if (nt == 2) begin
            cmd_protect = 1'b1; cmd_addr_t = BASE_T[4]; cmd_addr_b = BASE_B[4];
         end else begin
            cmd_protect = 1'b0;
         end
         if (nt == PC) begin
            look(BASE_T[2], BASE_B[2]);
            chk("R6 flag not yet set top", vfy_t, 8'h00);
            chk("R6 flag not yet set bottom", vfy_b, 8'h00);
         end
         @(negedge clk);
      end
      cmd_protect = 1'b0;
      chk("R6 lock busy length", nt, PC);
      look(BASE_T[2], BASE_B[2]);
      chk("R6 flag set top", vfy_t, 8'h01);
      chk("R6 flag set bottom", vfy_b, 8'h01);
      look(BASE_T[4], BASE_B[4]);
      chk("R9 busy request ignored top", vfy_t, 8'h00);
      chk("R9 busy request ignored bottom", vfy_b, 8'h00);

      // Clear with only one sector locked: refused.
      issue(0, 1, 19'h0, 19'h0);
      chk("R7 refused busy top", busy_t, 0);
      chk("R7 refused busy bottom", busy_b, 0);
      look(BASE_T[2], BASE_B[2]);
      chk("R7 refused keeps flag", vfy_t, 8'h01);

      // Table walk: lock sectors in address order, probe the sector edges.
      for (int i = 0; i < 11; i++) begin
         issue(1, 0, last_of(1, i), last_of(0, i));
         count_busy(nt, nb);
         chk("R6 busy length walk", nt, PC);
         look(BASE_T[i], BASE_B[i]);
         chk("R1 sector start locked", vfy_t, 8'h01);
         chk("R2 sector start locked", vfy_b, 8'h01);
         chk("R4 blocked top", pe_allow_t, 0);
         chk("R4 blocked bottom", pe_allow_b, 0);
         look(last_of(1, i), last_of(0, i));
         chk("R1 sector end locked", vfy_t, 8'h01);
         chk("R2 sector end locked", vfy_b, 8'h01);
         if (i < 10 && i != 1 && i != 3) begin
            look(BASE_T[i+1], BASE_B[i+1]);
            chk("R1 next sector open", vfy_t, 8'h00);
            chk("R2 next sector open", vfy_b, 8'h00);
            chk("R4 next sector allowed", pe_allow_t, 1);
         end
      end

      // Override.
      temp_unlock = 1'b1;
      look(BASE_T[3], BASE_B[9]);
      chk("R5 override top", pe_allow_t, 1);
      chk("R5 override bottom", pe_allow_b, 1);
      chk("R3 verify unaffected by override", vfy_t, 8'h01);
      temp_unlock = 1'b0;
      look(BASE_T[3], BASE_B[9]);
      chk("R5 release restores top", pe_allow_t, 0);
      chk("R5 release restores bottom", pe_allow_b, 0);

      // Reset keeps the flags.
      do_reset();
      look(BASE_T[5], BASE_B[5]);
      chk("R10 flags kept top", vfy_t, 8'h01);
      chk("R10 flags kept bottom", vfy_b, 8'h01);

      // Same-cycle lock and clear: lock wins.
      issue(1, 1, BASE_T[0], BASE_B[0]);
      count_busy(nt, nb);
      chk("R9 lock wins busy length", nt, PC);
      look(BASE_T[7], BASE_B[7]);
      chk("R9 clear not run", vfy_t, 8'h01);

      // Reset in the middle of a clear.
      issue(0, 1, 19'h0, 19'h0);
      repeat (4) @(negedge clk);
      chk("R8 clear started", busy_t, 1);
      do_reset();
      chk("R10 busy dropped", busy_t, 0);
      look(BASE_T[0], BASE_B[10]);
      chk("R10 abort keeps flags top", vfy_t, 8'h01);
      chk("R10 abort keeps flags bottom", vfy_b, 8'h01);

      // Full clear.
      issue(0, 1, 19'h0, 19'h0);
      count_busy(nt, nb);
      chk("R8 clear length", nt, UC);
      look(BASE_T[10], BASE_B[0]);
      chk("R8 all open top", vfy_t, 8'h00);
      chk("R8 all open bottom", vfy_b, 8'h00);
      chk("R4 allowed after clear", pe_allow_b, 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule